// File: doc/BRIEF.md
# Pattern-Framed Serial Command Receiver

This block receives command blocks for a display controller over a two-wire synchronous serial link: a shift clock and a data line. Both wires are brought into the system clock domain through flop synchronizers. The data line is sampled whenever a falling edge of the shift clock is seen. The receiver has no chip-select. It watches the bit stream through a short shift buffer and compares that buffer against a fixed synchronization pattern after every sampled bit.

When the pattern matches, the bit after it starts a block. A block is eleven bits: a 3-bit register address followed by an 8-bit data byte. Each block lands in a landing buffer and then moves to an output buffer. The consumer drains the output buffer with a valid/ready handshake. While either buffer holds data, a busy flag is raised and any further block is dropped. A sticky overrun flag records each drop. To frame the next block, the sender must send the full pattern again.

Top module: `sync_frame_rx`

## Requirements
- R1: Data is taken only on a falling edge of the synchronized shift clock. The level of the data line while the shift clock is high or rising has no effect.
- R2: After each sampled bit, the last four sampled bits are compared with the parameter SYNC_PATTERN (default 4'b1010). The earliest of the four bits is the most significant. Bits that come before a match are discarded.
- R3: A block is eleven bits, sent least significant bit first. The first three bits are the address (bit 0 first) and the next eight are the data byte (bit 0 first). They appear on blkAddr and blkData.
- R4: Reset fills the pattern buffer with ones. The bits 1,0 sent straight after reset, followed by a stream with no 1010 window, frame no block.
- R5: The first bit sampled after the match is address bit 0.
- R6: Each match refills the pattern buffer with ones. Bits sent after a block are ignored until the whole pattern has been sent again. Pattern bits left over from the previous frame do not count.
- R7: An accepted block is presented with blkValid high. blkValid, blkAddr and blkData stay unchanged until a cycle with blkReady high releases the block.
- R8: A block that completes is accepted only if both buffers are empty. Otherwise it is discarded, and the block already held is not changed.
- R9: busy is 0 after reset. It is 1 from the acceptance of a block until the consumer releases that block.
- R10: overrun is 0 after reset. It is set by each discarded block and cleared by a one-cycle ovrClr pulse. If a discard and ovrClr happen in the same cycle, overrun is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | External shift clock, idle high |
| serData | input | 1 | External serial data |
| blkReady | input | 1 | Consumer takes the presented block |
| ovrClr | input | 1 | Write-one pulse clearing overrun |
| blkValid | output | 1 | A block is presented |
| blkAddr | output | 3 | Register address of presented block |
| blkData | output | 8 | Data byte of presented block |
| busy | output | 1 | A buffer holds unprocessed data |
| overrun | output | 1 | Sticky flag: a block was discarded |

## Verification
The discard of a block that completes while the buffers are occupied can land in the same system cycle as a software clear of the overrun flag. The bench drives the last bit's shift-clock fall at a known time. It counts the synchronizer stages and raises ovrClr for exactly the cycle in which the discard is registered. Afterwards overrun must read 1. A clear on its own must then take it to 0.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef struct packed {
    logic shiftSync;
    logic armSync;
    logic shiftBlk;
    logic complete;
  } sfrStrobes_t;

endpackage

// File: rtl/sfr_edge_sync.sv
module sfr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serData,
  output logic fallEdge,
  output logic bitVal
);

  logic [STAGES-1:0] clkPipe;
  logic [STAGES-1:0] datPipe;
  logic              clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '1;
      datPipe <= '1;
      clkPrev <= 1'b1;
    end else begin
      clkPipe <= {clkPipe[STAGES-2:0], serClk};
      datPipe <= {datPipe[STAGES-2:0], serData};
      clkPrev <= clkPipe[STAGES-1];
    end
  end

  assign fallEdge = clkPrev & ~clkPipe[STAGES-1];
  assign bitVal   = datPipe[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> !fallEdge); // R1

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int BLK_BITS = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fallEdge,
  input  logic        matchNext,
  output sfrStrobes_t strb
);

  localparam int CW = $clog2(BLK_BITS);
  localparam logic [CW-1:0] LAST = CW'(BLK_BITS - 1);

  typedef enum logic {HUNT, CAPT} rxState_t;

  rxState_t  state, stateNext;
  logic [CW-1:0] bitCnt, bitCntNext;

  always_comb begin
    strb       = '0;
    stateNext  = state;
    bitCntNext = bitCnt;
    if (fallEdge) begin
      if (state == HUNT) begin
        strb.shiftSync = 1'b1;
        if (matchNext) begin
          strb.armSync = 1'b1;
          stateNext    = CAPT;
          bitCntNext   = '0;
        end
      end else begin
        strb.shiftBlk = 1'b1;
        if (bitCnt == LAST) begin
          strb.complete = 1'b1;
          stateNext     = HUNT;
          bitCntNext    = '0;
        end else begin
          bitCntNext = bitCnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= HUNT;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST); // R3

  AST_COMPLETE_HUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.complete |=> (state == HUNT)); // R6

  AST_MATCH_CAPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.armSync |=> (state == CAPT) && (bitCnt == '0)); // R5

endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int SYNC_W = 4,
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 4'b1010,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitVal,
  input  sfrStrobes_t       strb,
  input  logic              blkReady,
  input  logic              ovrClr,
  output logic              matchNext,
  output logic              blkValid,
  output logic [ADDR_W-1:0] blkAddr,
  output logic [DATA_W-1:0] blkData,
  output logic              busy,
  output logic              overrun
);

  localparam int BLK_BITS = ADDR_W + DATA_W;

  logic [SYNC_W-1:0]   syncBuf;
  logic [SYNC_W-1:0]   syncShifted;
  logic [BLK_BITS-1:0] blkSr;
  logic [BLK_BITS-1:0] blkWord;
  logic [BLK_BITS-1:0] landBuf, outBuf;
  logic                landFull, outFull;
  logic                accept, drop, moveOut, release_;

  assign syncShifted = {syncBuf[SYNC_W-2:0], bitVal};
  assign matchNext   = (syncShifted == SYNC_PATTERN);
  assign blkWord     = {bitVal, blkSr[BLK_BITS-1:1]};

  assign accept   = strb.complete && !landFull && !outFull;
  assign drop     = strb.complete && (landFull || outFull);
  assign moveOut  = landFull && !outFull;
  assign release_ = outFull && blkReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncBuf <= '1;
      blkSr   <= '0;
    end else begin
      if (strb.armSync)        syncBuf <= '1;
      else if (strb.shiftSync) syncBuf <= syncShifted;
      if (strb.shiftBlk)       blkSr   <= blkWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      landBuf  <= '0;
      outBuf   <= '0;
      landFull <= 1'b0;
      outFull  <= 1'b0;
    end else begin
      if (accept) begin
        landBuf  <= blkWord;
        landFull <= 1'b1;
      end else if (moveOut) begin
        landFull <= 1'b0;
      end
      if (moveOut) begin
        outBuf  <= landBuf;
        outFull <= 1'b1;
      end else if (release_) begin
        outFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       overrun <= 1'b0;
    else if (drop)   overrun <= 1'b1;
    else if (ovrClr) overrun <= 1'b0;
  end

  assign blkValid = outFull;
  assign blkAddr  = outBuf[ADDR_W-1:0];
  assign blkData  = outBuf[BLK_BITS-1:ADDR_W];
  assign busy     = landFull | outFull;

  AST_ARM_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.armSync |=> (syncBuf == '1)); // R6

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    blkValid && !blkReady |=> blkValid && $stable(blkAddr) && $stable(blkData)); // R7

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.complete && busy |=> overrun); // R10

  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.complete && blkValid && !blkReady |=> blkValid && $stable(blkData)); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !ovrClr |=> overrun); // R10

  AST_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.complete && !busy |=> busy); // R9

endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
  import sfr_pkg::*;
#(
  parameter int SYNC_W = 4,
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 4'b1010,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              blkReady,
  input  logic              ovrClr,
  output logic              blkValid,
  output logic [ADDR_W-1:0] blkAddr,
  output logic [DATA_W-1:0] blkData,
  output logic              busy,
  output logic              overrun
);

  localparam int BLK_BITS = ADDR_W + DATA_W;

  logic        fallEdge, bitVal, matchNext;
  sfrStrobes_t strb;

  sfr_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .fallEdge(fallEdge), .bitVal(bitVal)
  );

  sfr_ctrl #(.BLK_BITS(BLK_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .matchNext(matchNext),
    .strb(strb)
  );

  sfr_datapath #(
    .SYNC_W(SYNC_W), .SYNC_PATTERN(SYNC_PATTERN),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitVal(bitVal), .strb(strb),
    .blkReady(blkReady), .ovrClr(ovrClr), .matchNext(matchNext),
    .blkValid(blkValid), .blkAddr(blkAddr), .blkData(blkData),
    .busy(busy), .overrun(overrun)
  );

endmodule

// File: tb/sync_frame_rx_tb.sv
`timescale 1ns/1ps
module sync_frame_rx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b1;
  logic       serData = 1'b1;
  logic       blkReady = 1'b0;
  logic       ovrClr = 1'b0;
  logic       blkValid, busy, overrun;
  logic [2:0] blkAddr;
  logic [7:0] blkData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .blkReady(blkReady), .ovrClr(ovrClr), .blkValid(blkValid),
    .blkAddr(blkAddr), .blkData(blkData), .busy(busy), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // While the shift clock is high the data line carries the inverse of the bit,
  // so sampling on a rising edge would give the wrong value (R1).
  task automatic sendBit(input logic b, input bit collide = 0);
    @(negedge clk);
    serData = ~b;
    serClk  = 1'b1;
    repeat (2) @(negedge clk);
    serData = b;
    repeat (2) @(negedge clk);
    serClk = 1'b0;
    if (collide) begin
      repeat (2) @(negedge clk);
      ovrClr = 1'b1;
      @(negedge clk);
      ovrClr = 1'b0;
      @(negedge clk);
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic sendSync();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
  endtask

  task automatic sendBlock(input logic [2:0] a, input logic [7:0] d, input bit collide = 0);
    sendSync();
    for (int i = 0; i < 3; i++) sendBit(a[i]);
    for (int i = 0; i < 7; i++) sendBit(d[i]);
    sendBit(d[7], collide);
  endtask

  task automatic sendQuiet();
    for (int i = 0; i < 12; i++) sendBit(logic'((i % 4) >= 2));
  endtask

  task automatic waitValid();
    for (int i = 0; i < 30 && !blkValid; i++) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk); blkReady = 1'b1;
    @(negedge clk); blkReady = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 reset valid", blkValid, 0);
    check("R9 reset busy", busy, 0);
    check("R10 reset overrun", overrun, 0);
    sendBit(1'b1); sendBit(1'b0);
    sendQuiet();
    repeat (20) @(negedge clk);
    check("R4 no false frame after reset", blkValid, 0);
  endtask

  task automatic t_single();
    sendBlock(3'd5, 8'hC3);
    waitValid();
    check("R7 valid after block", blkValid, 1);
    check("R5 address framing", blkAddr, 5);
    check("R3 data lsb first", blkData, 8'hC3);
    check("R1 falling edge sampling", blkData, 8'hC3);
    check("R9 busy while held", busy, 1);
    repeat (6) @(negedge clk);
    check("R7 held without ready", {blkValid, blkAddr, blkData}, {1'b1, 3'd5, 8'hC3});
    drain();
    check("R7 released", blkValid, 0);
    check("R9 busy cleared", busy, 0);
  endtask

  task automatic t_search();
    sendBit(0); sendBit(0); sendBit(1); sendBit(1);
    sendBit(0); sendBit(0); sendBit(1); sendBit(1);
    sendBlock(3'd2, 8'h3C);
    waitValid();
    check("R2 match after noise addr", blkAddr, 2);
    check("R2 match after noise data", blkData, 8'h3C);
    drain();
  endtask

  task automatic t_rearm();
    sendBlock(3'd1, 8'h5A);
    waitValid();
    check("R3 block before rearm", blkData, 8'h5A);
    drain();
    sendBit(1'b1); sendBit(1'b0);
    sendQuiet();
    repeat (20) @(negedge clk);
    check("R6 no block without fresh pattern", blkValid, 0);
    check("R6 not busy", busy, 0);
  endtask

  task automatic t_drop();
    sendBlock(3'd3, 8'h81);
    waitValid();
    sendBlock(3'd6, 8'h7E);
    repeat (10) @(negedge clk);
    check("R10 overrun on drop", overrun, 1);
    check("R8 held block kept", {blkValid, blkAddr, blkData}, {1'b1, 3'd3, 8'h81});
    drain();
    check("R8 dropped block absent", blkValid, 0);
    sendBlock(3'd4, 8'h11);
    waitValid();
    check("R8 accept when empty", {blkAddr, blkData}, {3'd4, 8'h11});
    check("R10 overrun sticky", overrun, 1);
  endtask

  task automatic t_collide();
    sendBlock(3'd7, 8'hEE, 1);
    repeat (4) @(negedge clk);
    check("R10 set wins over clear", overrun, 1);
    check("R8 held block kept on collide", {blkAddr, blkData}, {3'd4, 8'h11});
    @(negedge clk); ovrClr = 1'b1;
    @(negedge clk); ovrClr = 1'b0;
    @(negedge clk);
    check("R10 clear pulse", overrun, 0);
    drain();
    check("R9 idle at end", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_search();
    t_rearm();
    t_drop();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule